// File: doc/BRIEF.md
# OTP Shadow Register ECC Loader

This block runs once per wakeup. It fills a bank of volatile shadow registers from a one-time-programmable store. When a wake request arrives, it first writes each shadow block with its hardware default value. It then reads the store one 72-bit codeword at a time, in ascending block order. Each codeword passes through a single-error-correct, double-error-detect decoder. A block with no error, or with one flipped bit, is written into the shadow bank. A block that cannot be corrected is skipped and keeps its default.

Two sticky flags report corrected and uncorrectable events. Each flag has a register that holds the index of the latest block of that kind. The flags stay set until software pulses the clear input. The block count, the default image, the shadow base address and the address width are all parameters. With the default six blocks, the loader covers shadow bytes 0x0000 to 0x002F.

Top module: `otp_shadow_loader`

## Requirements
- R1: When `wake_i` is sampled high in idle, the shadow port writes defaults for blocks 0 to N-1. These writes fall in N consecutive cycles, starting in the cycle after the wake edge. Block b receives `DFLT_IMAGE[64b+63:64b]`.
- R2: After the default writes, each block takes two cycles. In the first, `otp_rd_o` is high with `otp_idx_o` = b, and the store must return that word on `otp_rdata_i` in the next cycle. The codeword layout is as follows. Bit 0 gives even parity over all 72 bits. Bits 1, 2, 4, 8, 16, 32 and 64 are check bits; the check bit at 2^j gives even parity over every position whose index has bit j set. The remaining positions hold data bits d0 to d63 in ascending order.
- R3: A codeword with no error is written unchanged, in the cycle in which it is presented.
- R4: A codeword with exactly one flipped bit, at any of the 72 positions, is corrected and written. In the next cycle `sec_flag_o` is set and `sec_blk_o` holds the block index.
- R5: Some codewords cannot be corrected: two flipped bits, or an odd overall parity with a syndrome of 72 or more. Such a codeword causes no write. In the next cycle `ded_flag_o` is set and `ded_blk_o` holds the block index.
- R6: The decision for each block is independent of the others. Blocks after a rejected block still load. Each location register keeps the index of the most recent block of its kind.
- R7: `done_o` is high for exactly one cycle, 3N+1 cycles after the wake edge. No read or write follows it.
- R8: The flags hold until `clr_flags_i` is sampled high, which clears both flags. An event in the same cycle as the clear wins. The location registers and any load in progress are not affected by a clear.
- R9: `wake_i` is ignored while a load is running, including the cycle in which `done_o` is high.
- R10: After reset, every output is zero.
- R11: Block b is written at shadow address `BASE_ADDR + 8b`. Data byte k (bits 8k+7:8k) belongs at `BASE_ADDR + 8b + k`. With the defaults, the loader covers 0x0000 to 0x002F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wake_i | input | 1 | Starts a load when idle |
| clr_flags_i | input | 1 | Clears both sticky flags |
| otp_rd_o | output | 1 | Read request to the OTP store |
| otp_idx_o | output | IDX_W | Block index of the read |
| otp_rdata_i | input | 72 | Codeword returned one cycle after the request |
| shw_we_o | output | 1 | Shadow write strobe |
| shw_addr_o | output | ADDR_W | Shadow byte address of the block's first byte |
| shw_data_o | output | 64 | Shadow write data |
| done_o | output | 1 | One-cycle end-of-load pulse |
| sec_flag_o | output | 1 | Sticky corrected-error flag |
| ded_flag_o | output | 1 | Sticky uncorrectable-error flag |
| sec_blk_o | output | IDX_W | Index of the latest corrected block |
| ded_blk_o | output | IDX_W | Index of the latest rejected block |

## Verification
Timing is counted from the edge that samples the wake request. Defaults for block b appear in cycle b+1. The read for block b is in cycle N+1+2b, and its corrected or rejected result is on the write port in cycle N+2+2b. The flags and location registers change one cycle after that, and `done_o` is high in cycle 3N+1. The reference model in the bench builds the expected port values cycle by cycle from these offsets and compares every output at each falling edge. Clear and wake pulses are placed on exact offsets, including the check cycle of an erroring block and the done cycle, so the clear priority and the ignoring of wake are checked in the cycle where they matter.

// File: rtl/otp_ld_pkg.sv
package otp_ld_pkg;

   localparam int DATA_W        = 64;
   localparam int CODE_W        = 72;
   localparam int SYN_W         = 7;
   localparam int BYTES_PER_BLK = DATA_W / 8;

   typedef enum logic [1:0] {
      ECC_CLEAN = 2'd0,
      ECC_FIXED = 2'd1,
      ECC_FATAL = 2'd2
   } ecc_res_e;

   typedef enum logic [2:0] {
      LD_IDLE  = 3'd0,
      LD_DFLT  = 3'd1,
      LD_FETCH = 3'd2,
      LD_CHECK = 3'd3,
      LD_FIN   = 3'd4
   } ld_state_e;

   // codeword position of data bit idx: the idx-th position that is not a power of two
   function automatic int data_slot(int idx);
      int n;
      int r;
      n = 0;
      r = 0;
      for (int p = 1; p < CODE_W; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (n == idx) r = p;
            n++;
         end
      end
      return r;
   endfunction

   // positions whose index has bit j set
   function automatic logic [CODE_W-1:0] cover_mask(int j);
      logic [CODE_W-1:0] m;
      m = '0;
      for (int p = 0; p < CODE_W; p++) begin
         if (((p >> j) & 1) == 1) m[p] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/otp_ld_secded_dec.sv
module otp_ld_secded_dec
   import otp_ld_pkg::*;
(
   input  logic [CODE_W-1:0] cw_i,
   output logic [DATA_W-1:0] data_o,
   output ecc_res_e          res_o
);

   logic [SYN_W-1:0]  syn;
   logic              all_par;
   logic [CODE_W-1:0] flip;
   logic [CODE_W-1:0] fixed_cw;

   for (genvar j = 0; j < SYN_W; j++) begin : g_syn
      localparam logic [CODE_W-1:0] MSK = cover_mask(j);
      assign syn[j] = ^(cw_i & MSK);
   end

   assign all_par = ^cw_i;

   always_comb begin
      flip  = '0;
      res_o = ECC_CLEAN;
      if (all_par) begin
         if (syn < SYN_W'(CODE_W)) begin
            res_o = ECC_FIXED;
            flip  = CODE_W'(1) << syn;
         end else begin
            res_o = ECC_FATAL;
         end
      end else if (syn != '0) begin
         res_o = ECC_FATAL;
      end
   end

   assign fixed_cw = cw_i ^ flip;

   for (genvar i = 0; i < DATA_W; i++) begin : g_dat
      localparam int P = data_slot(i);
      assign data_o[i] = fixed_cw[P];
   end

endmodule

// File: rtl/otp_ld_sticky.sv
module otp_ld_sticky #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic             clr_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic             flag_o,
   output logic [IDX_W-1:0] loc_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         loc_o  <= '0;
      end else if (set_i) begin
         flag_o <= 1'b1;
         loc_o  <= idx_i;
      end else if (clr_i) begin
         flag_o <= 1'b0;
      end
   end

   assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);

   assert_loc_latest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> (loc_o == $past(idx_i)));

   assert_loc_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !set_i |=> $stable(loc_o));

endmodule

// File: rtl/otp_ld_seq.sv
module otp_ld_seq
   import otp_ld_pkg::*;
#(
   parameter int                           NUM_BLOCKS = 6,
   parameter logic [NUM_BLOCKS*DATA_W-1:0] DFLT_IMAGE = '0,
   localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wake_i,
   output logic              otp_rd_o,
   output logic [IDX_W-1:0]  otp_idx_o,
   input  logic [DATA_W-1:0] dec_data_i,
   input  ecc_res_e          dec_res_i,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              done_o,
   output logic              sec_evt_o,
   output logic              ded_evt_o,
   output logic [IDX_W-1:0]  evt_idx_o
);

   ld_state_e        st_q, st_d;
   logic [IDX_W-1:0] cnt_q, cnt_d;
   logic             last;

   assign last = (cnt_q == IDX_W'(NUM_BLOCKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= LD_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   always_comb begin
      st_d      = st_q;
      cnt_d     = cnt_q;
      otp_rd_o  = 1'b0;
      wr_en_o   = 1'b0;
      wr_data_o = dec_data_i;
      done_o    = 1'b0;
      sec_evt_o = 1'b0;
      ded_evt_o = 1'b0;
      unique case (st_q)
         LD_IDLE: begin
            if (wake_i) begin
               st_d  = LD_DFLT;
               cnt_d = '0;
            end
         end
         LD_DFLT: begin
            wr_en_o   = 1'b1;
            wr_data_o = DFLT_IMAGE[int'(cnt_q)*DATA_W +: DATA_W];
            if (last) begin
               st_d  = LD_FETCH;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         LD_FETCH: begin
            otp_rd_o = 1'b1;
            st_d     = LD_CHECK;
         end
         LD_CHECK: begin
            unique case (dec_res_i)
               ECC_CLEAN: wr_en_o = 1'b1;
               ECC_FIXED: begin
                  wr_en_o   = 1'b1;
                  sec_evt_o = 1'b1;
               end
               default:   ded_evt_o = 1'b1;
            endcase
            if (last) begin
               st_d = LD_FIN;
            end else begin
               cnt_d = cnt_q + 1'b1;
               st_d  = LD_FETCH;
            end
         end
         LD_FIN: begin
            done_o = 1'b1;
            st_d   = LD_IDLE;
         end
         default: st_d = LD_IDLE;
      endcase
   end

   assign otp_idx_o = cnt_q;
   assign wr_idx_o  = cnt_q;
   assign evt_idx_o = cnt_q;

   assert_fetch_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      otp_rd_o |=> (!otp_rd_o && st_q == LD_CHECK));

   assert_defaults_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LD_FETCH && cnt_q == '0) |-> ($past(st_q) == LD_DFLT && $past(wr_en_o)));

   assert_reject_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ded_evt_o |-> !wr_en_o);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !wr_en_o && !otp_rd_o));

   assert_wake_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != LD_IDLE && st_q != LD_DFLT) |=> (st_q != LD_DFLT));

endmodule

// File: rtl/otp_shadow_loader.sv
module otp_shadow_loader
   import otp_ld_pkg::*;
#(
   parameter int                           NUM_BLOCKS = 6,
   parameter int                           ADDR_W     = 16,
   parameter int                           BASE_ADDR  = 0,
   parameter logic [NUM_BLOCKS*DATA_W-1:0] DFLT_IMAGE = {NUM_BLOCKS{64'hFFFF_0000_FFFF_0000}},
   localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wake_i,
   input  logic              clr_flags_i,
   output logic              otp_rd_o,
   output logic [IDX_W-1:0]  otp_idx_o,
   input  logic [CODE_W-1:0] otp_rdata_i,
   output logic              shw_we_o,
   output logic [ADDR_W-1:0] shw_addr_o,
   output logic [DATA_W-1:0] shw_data_o,
   output logic              done_o,
   output logic              sec_flag_o,
   output logic              ded_flag_o,
   output logic [IDX_W-1:0]  sec_blk_o,
   output logic [IDX_W-1:0]  ded_blk_o
);

   localparam int NUM_KINDS = 2;

   if (NUM_BLOCKS < 1) begin : g_bad_blocks
      $error("otp_shadow_loader: NUM_BLOCKS must be at least one");
   end
   if ((64'(BASE_ADDR) + 64'(NUM_BLOCKS * BYTES_PER_BLK)) > (64'd1 << ADDR_W)) begin : g_bad_addr
      $error("otp_shadow_loader: shadow range exceeds ADDR_W");
   end

   logic [DATA_W-1:0] dec_data;
   ecc_res_e          dec_res;
   logic [IDX_W-1:0]  wr_idx;
   logic [IDX_W-1:0]  evt_idx;
   logic [NUM_KINDS-1:0] evt;
   logic [NUM_KINDS-1:0] flag;
   logic [IDX_W-1:0]  loc [NUM_KINDS];

   otp_ld_secded_dec u_dec (
      .cw_i   (otp_rdata_i),
      .data_o (dec_data),
      .res_o  (dec_res)
   );

   otp_ld_seq #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .DFLT_IMAGE (DFLT_IMAGE)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wake_i     (wake_i),
      .otp_rd_o   (otp_rd_o),
      .otp_idx_o  (otp_idx_o),
      .dec_data_i (dec_data),
      .dec_res_i  (dec_res),
      .wr_en_o    (shw_we_o),
      .wr_idx_o   (wr_idx),
      .wr_data_o  (shw_data_o),
      .done_o     (done_o),
      .sec_evt_o  (evt[0]),
      .ded_evt_o  (evt[1]),
      .evt_idx_o  (evt_idx)
   );

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_flag
      otp_ld_sticky #(.IDX_W(IDX_W)) u_sticky (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (evt[k]),
         .clr_i  (clr_flags_i),
         .idx_i  (evt_idx),
         .flag_o (flag[k]),
         .loc_o  (loc[k])
      );
   end

   assign sec_flag_o = flag[0];
   assign ded_flag_o = flag[1];
   assign sec_blk_o  = loc[0];
   assign ded_blk_o  = loc[1];

   assign shw_addr_o = ADDR_W'(BASE_ADDR + int'(wr_idx) * BYTES_PER_BLK);

   assert_addr_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      shw_we_o |-> (int'(shw_addr_o) < BASE_ADDR + NUM_BLOCKS * BYTES_PER_BLK));

   assert_one_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evt));

endmodule

// File: tb/otp_shadow_loader_tb_top.sv
`timescale 1ns/1ps
module otp_shadow_loader_tb_top;

   localparam int NB = 6;
   localparam int IW = $clog2(NB);

   function automatic logic [63:0] dflt_of(int b);
      return {16'hC0DE, 16'(b), 32'h5EED_0000 | 32'(b * 17)};
   endfunction

   function automatic logic [NB*64-1:0] mk_img();
      logic [NB*64-1:0] img;
      img = '0;
      for (int b = 0; b < NB; b++) img[b*64 +: 64] = dflt_of(b);
      return img;
   endfunction

   localparam logic [NB*64-1:0] IMG = mk_img();

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wake_i = 1'b0;
   logic          clr_i = 1'b0;
   logic          otp_rd_o;
   logic [IW-1:0] otp_idx_o;
   logic [71:0]   otp_rdata = '0;
   logic          shw_we_o;
   logic [15:0]   shw_addr_o;
   logic [63:0]   shw_data_o;
   logic          done_o;
   logic          sec_flag_o, ded_flag_o;
   logic [IW-1:0] sec_blk_o, ded_blk_o;

   always #10 clk = ~clk;

   otp_shadow_loader #(
      .NUM_BLOCKS (NB),
      .ADDR_W     (16),
      .BASE_ADDR  (0),
      .DFLT_IMAGE (IMG)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wake_i      (wake_i),
      .clr_flags_i (clr_i),
      .otp_rd_o    (otp_rd_o),
      .otp_idx_o   (otp_idx_o),
      .otp_rdata_i (otp_rdata),
      .shw_we_o    (shw_we_o),
      .shw_addr_o  (shw_addr_o),
      .shw_data_o  (shw_data_o),
      .done_o      (done_o),
      .sec_flag_o  (sec_flag_o),
      .ded_flag_o  (ded_flag_o),
      .sec_blk_o   (sec_blk_o),
      .ded_blk_o   (ded_blk_o)
   );

   // behavioural OTP store, one cycle read latency
   logic [71:0] otp_mem [NB];
   always @(posedge clk) if (otp_rd_o) otp_rdata <= otp_mem[otp_idx_o];

   logic [63:0] blk_data [NB];
   int          blk_cls  [NB];   // 0 clean, 1 corrected, 2 rejected

   int  n_vec = 0;
   int  n_bad = 0;
   int  cyc   = 0;
   bit  m_sec = 0, m_ded = 0;
   int  m_sec_loc = 0, m_ded_loc = 0;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   function automatic logic [71:0] encode(logic [63:0] d);
      logic [71:0] w;
      int k;
      w = '0;
      k = 0;
      for (int p = 1; p < 72; p++) begin
         if ((p & (p - 1)) != 0) begin
            w[p] = d[k];
            k++;
         end
      end
      for (int j = 0; j < 7; j++) begin
         logic par;
         par = 1'b0;
         for (int p = 1; p < 72; p++) if (((p >> j) & 1) == 1) par = par ^ w[p];
         w[1 << j] = par;
      end
      w[0] = ^w[71:1];
      return w;
   endfunction

   task automatic chk(string tag, string what, logic [71:0] act, logic [71:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic set_blk(int b, logic [63:0] d, logic [71:0] err, int cls);
      blk_data[b] = d;
      blk_cls[b]  = cls;
      otp_mem[b]  = encode(d) ^ err;
   endtask

   // cycle-by-cycle reference: offset n counts falling edges after the wake edge
   task automatic run_load(int clr_off, int wake_off, string rtag);
      int total;
      total  = 3 * NB + 3;
      wake_i = 1'b1;
      for (int n = 1; n <= total; n++) begin
         logic          e_we, e_rd, e_done, is_chk;
         logic [15:0]   e_addr;
         logic [63:0]   e_data;
         logic [IW-1:0] e_idx;
         int            b, m;
         string         wt;
         @(negedge clk);
         e_we = 1'b0; e_rd = 1'b0; e_done = 1'b0; is_chk = 1'b0;
         e_addr = '0; e_data = '0; e_idx = '0; b = 0; wt = "R7";
         if (n <= NB) begin
            b = n - 1; e_we = 1'b1; e_addr = 16'(8 * b); e_data = dflt_of(b); wt = "R1";
         end else if (n <= 3 * NB) begin
            m = n - NB - 1;
            b = m / 2;
            if (m % 2 == 0) begin
               e_rd = 1'b1; e_idx = IW'(b);
            end else begin
               is_chk = 1'b1;
               e_we   = (blk_cls[b] != 2);
               e_addr = 16'(8 * b);
               e_data = blk_data[b];
               wt     = (blk_cls[b] == 0) ? "R3" : (blk_cls[b] == 1) ? "R4" : "R5";
            end
         end else if (n == 3 * NB + 1) begin
            e_done = 1'b1;
         end
         chk({rtag, wt}, "write strobe", 72'(shw_we_o), 72'(e_we));
         if (e_we) begin
            chk({rtag, "R11"}, "write address", 72'(shw_addr_o), 72'(e_addr));
            chk({rtag, wt}, "write data", 72'(shw_data_o), 72'(e_data));
         end
         chk({rtag, "R2"}, "read request", 72'(otp_rd_o), 72'(e_rd));
         if (e_rd) chk({rtag, "R2"}, "read index", 72'(otp_idx_o), 72'(e_idx));
         chk({rtag, "R7"}, "done pulse", 72'(done_o), 72'(e_done));
         chk({rtag, "R8"}, "single flag", 72'(sec_flag_o), 72'(m_sec));
         chk({rtag, "R8"}, "double flag", 72'(ded_flag_o), 72'(m_ded));
         chk({rtag, "R6"}, "single location", 72'(sec_blk_o), 72'(m_sec_loc));
         chk({rtag, "R6"}, "double location", 72'(ded_blk_o), 72'(m_ded_loc));
         // model state after this cycle's edge
         begin
            bit ev_s, ev_d, clr_now;
            ev_s    = is_chk && blk_cls[b] == 1;
            ev_d    = is_chk && blk_cls[b] == 2;
            clr_now = (n == clr_off);
            if (ev_s) m_sec_loc = b;
            if (ev_d) m_ded_loc = b;
            m_sec = ev_s || (m_sec && !clr_now);
            m_ded = ev_d || (m_ded && !clr_now);
         end
         clr_i  = (n == clr_off);
         wake_i = (n == wake_off);
      end
      clr_i  = 1'b0;
      wake_i = 1'b0;
   endtask

   initial begin
      for (int b = 0; b < NB; b++) set_blk(b, '0, '0, 0);
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "write strobe", 72'(shw_we_o), 72'(0));
      chk("R10", "read request", 72'(otp_rd_o), 72'(0));
      chk("R10", "done", 72'(done_o), 72'(0));
      chk("R10", "flags", 72'({sec_flag_o, ded_flag_o}), 72'(0));
      chk("R10", "locations", 72'({sec_blk_o, ded_blk_o}), 72'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "idle after release", 72'({shw_we_o, otp_rd_o, done_o}), 72'(0));

      // all blocks clean
      for (int b = 0; b < NB; b++) set_blk(b, {$urandom, $urandom}, '0, 0);
      run_load(0, 0, "");

      // single flip at every one of the 72 positions, six per load
      for (int r = 0; r < 12; r++) begin
         for (int b = 0; b < NB; b++) set_blk(b, {$urandom, $urandom}, 72'(1) << (r * NB + b), 1);
         run_load(0, 0, "");
      end

      // clear while idle: flags drop, locations stay
      clr_i = 1'b1;
      @(negedge clk);
      clr_i = 1'b0;
      m_sec = 0;
      m_ded = 0;
      chk("R8", "flags after idle clear", 72'({sec_flag_o, ded_flag_o}), 72'(0));
      chk("R8", "location after idle clear", 72'(sec_blk_o), 72'(m_sec_loc));

      // mixed blocks; clear lands on the check cycle of the last (corrected) block
      set_blk(0, {$urandom, $urandom}, 72'(1) << 3, 1);
      set_blk(1, {$urandom, $urandom}, '0, 0);
      set_blk(2, {$urandom, $urandom}, (72'(1) << 10) | (72'(1) << 40), 2);
      set_blk(3, {$urandom, $urandom}, '0, 0);
      set_blk(4, {$urandom, $urandom}, (72'(1) << 1) | (72'(1) << 8) | (72'(1) << 64), 2);
      set_blk(5, {$urandom, $urandom}, 72'(1) << 70, 1);
      run_load(NB + 2 + 2 * 5, 0, "");

      // R9: wake pulses during defaults and during fetches are ignored
      set_blk(0, {$urandom, $urandom}, (72'(1) << 0) | (72'(1) << 71), 2);
      set_blk(1, {$urandom, $urandom}, 72'(1) << 33, 1);
      for (int b = 2; b < NB; b++) set_blk(b, {$urandom, $urandom}, '0, 0);
      run_load(0, 4, "R9/");
      run_load(0, NB + 3, "R9/");
      // R9: wake in the done cycle is ignored
      run_load(0, 3 * NB + 1, "R9/");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule